// File: doc/BRIEF.md
# Gate-Drive Latch with Current-Sense Blanking

This block holds the on/off state of the power switch in a fixed-frequency, current-mode switching controller. Each oscillator period begins with a one-clock start pulse that turns the gate on. From then on, any of several termination sources can turn it off again: the regulation (PWM) comparator, the soft-start duty limiter, the cycle-by-cycle current limit, or the close of the maximum-duty window. The gate also stays low while the supply sits below its undervoltage threshold. All inputs are flags that have already been sampled into the system clock domain. The analog comparators sit outside the block.

When the switch turns on, the current-sense signal carries a spike. The three trips taken from current sense (PWM, full current limit, reduced current limit) are therefore ignored for a fixed number of system clocks after each rising edge of the gate. A burst-mode select picks which current-limit flag is honoured: the reduced-threshold flag in burst mode, the full-threshold flag otherwise. The soft-start trip counts only while soft-start has not yet finished. The gate enable is a registered output, so every effect appears one clock after the edge that samples its cause.

Top module: `gate_latch_leb`

## Requirements
- R1: While `rst_n` is sampled low, and in the cycle after, `gate_en` is 0.
- R2: With `cyc_start` high, `duty_win` high, `uv_low` low and no honoured trip, `gate_en` is 1 one clock later.
- R3: `pwm_trip` sampled high outside the blanking interval drives `gate_en` to 0 one clock later.
- R4: `ss_trip` drives `gate_en` to 0 one clock later while `ss_done` is 0. While `ss_done` is 1, `ss_trip` has no effect.
- R5: With `burst_sel` = 0, `ilim_full_trip` outside blanking turns the gate off one clock later, and `ilim_red_trip` has no effect.
- R6: With `burst_sel` = 1, `ilim_red_trip` outside blanking turns the gate off one clock later, and `ilim_full_trip` has no effect.
- R7: The first BLANK_CLKS clock edges after the edge that raised `gate_en` ignore the three current-sense trips. A trip held at the next edge (BLANK_CLKS+1) turns the gate off. Soft-start, duty-window and undervoltage resets are never blanked.
- R8: `duty_win` sampled low drives `gate_en` to 0 one clock later.
- R9: `uv_low` sampled high drives `gate_en` to 0 one clock later, and it overrides `cyc_start`.
- R10: When `cyc_start` coincides with any honoured reset, the reset wins and `gate_en` is 0 one clock later.
- R11: With no reset condition, `gate_en` holds its value. A `cyc_start` while the gate is already on does not restart the blanking interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock oscillator cycle-start pulse |
| duty_win | input | 1 | High while the maximum-duty window is open |
| pwm_trip | input | 1 | Regulation comparator tripped (current-sense derived) |
| ss_trip | input | 1 | Soft-start duty limiter tripped |
| ss_done | input | 1 | Soft-start has finished; disables `ss_trip` |
| ilim_full_trip | input | 1 | Full-threshold current limit tripped |
| ilim_red_trip | input | 1 | Reduced-threshold current limit tripped |
| burst_sel | input | 1 | 1 selects the reduced current-limit flag |
| uv_low | input | 1 | Supply below undervoltage off threshold |
| gate_en | output | 1 | Registered gate-drive enable |

## Verification
Two functions can fall in the same cycle. The first pair is set against reset: the bench raises `cyc_start` on the same clock as a soft-start trip, a closed duty window or an undervoltage flag, and it expects the gate to stay low. The second pair is the end of blanking against a held current-sense trip: a trip is asserted from the first edge after turn-on and kept high, and the gate must stay on through exactly BLANK_CLKS edges and drop on the next one. A behavioural reference model, written as a countdown, is compared with `gate_en` on every clock. The bench also repeats the blanking case with a second `cyc_start` inside the window, to show that the interval is not restarted.

// File: rtl/gl_pkg.sv
// Package: shared types and helpers for the gate latch.
// Assumes: all flags are synchronous to the system clock.
package gl_pkg;

    // Current-sense derived trip flags, grouped so they travel together.
    typedef struct packed {
        logic pwm;
        logic full;
        logic red;
    } cs_trips_t;

    // Counter width able to hold the value n.
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/gl_blank_timer.sv
// Module: counts BLANK_CLKS clocks after each gate turn-on and reports
// when current-sense trips may be honoured.
// Assumes: load is a one-clock pulse coinciding with the gate's rising edge.
module gl_blank_timer #(
    parameter int BLANK_CLKS = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic cs_enable
);
    localparam int CW = gl_pkg::cnt_width(BLANK_CLKS);

    generate
        if (BLANK_CLKS == 0) begin : g_noblank
            logic unused_load;
            assign unused_load = load ^ clk ^ rst_n;
            assign cs_enable = 1'b1;
        end else begin : g_blank
            logic [CW-1:0] remain;

            // Reload on turn-on, otherwise count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    remain <= '0;
                else if (load)
                    remain <= CW'(BLANK_CLKS);
                else if (remain != '0)
                    remain <= remain - 1'b1;
            end

            assign cs_enable = (remain == '0);
        end
    endgenerate
endmodule

// File: rtl/gl_trip_merge.sv
// Module: combines all latch reset sources into one clear request.
// Assumes: cs_enable is low during the blanking interval.
module gl_trip_merge (
    input  gl_pkg::cs_trips_t cs,
    input  logic              cs_enable,
    input  logic              burst_sel,
    input  logic              ss_trip,
    input  logic              ss_done,
    input  logic              duty_win,
    output logic              clr_req
);
    logic ilim_act;
    logic cs_clr;
    logic ss_clr;

    // Pick the current-limit flag for the present mode.
    always_comb ilim_act = burst_sel ? cs.red : cs.full;

    // Current-sense trips honoured only outside blanking.
    always_comb cs_clr = cs_enable & (cs.pwm | ilim_act);

    // Soft-start limiter only acts before soft-start completes.
    always_comb ss_clr = ss_trip & ~ss_done;

    // Any source, including closure of the duty window, clears.
    always_comb clr_req = cs_clr | ss_clr | ~duty_win;
endmodule

// File: rtl/gl_latch_core.sv
// Module: set/reset gate latch with reset priority and a forced-off input.
// Assumes: set_req is the cycle-start pulse; force_off is the UV flag.
module gl_latch_core (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic force_off,
    output logic gate,
    output logic turn_on
);
    logic gate_nx;

    // Next state: force-off, then clear, then set, else hold.
    always_comb begin
        if (force_off || clr_req)
            gate_nx = 1'b0;
        else if (set_req)
            gate_nx = 1'b1;
        else
            gate_nx = gate;
    end

    // Rising-edge indication used to restart blanking.
    always_comb turn_on = gate_nx & ~gate;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gate <= 1'b0;
        else
            gate <= gate_nx;
    end
endmodule

// File: rtl/gate_latch_leb.sv
// Module: top of the gate-drive latch with current-sense blanking.
// Assumes: inputs are synchronous flags; gate_en is registered.
module gate_latch_leb #(
    parameter int BLANK_CLKS = 28
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic duty_win,
    input  logic pwm_trip,
    input  logic ss_trip,
    input  logic ss_done,
    input  logic ilim_full_trip,
    input  logic ilim_red_trip,
    input  logic burst_sel,
    input  logic uv_low,
    output logic gate_en
);
    gl_pkg::cs_trips_t cs;
    logic cs_enable;
    logic clr_req;
    logic turn_on;

    // Bundle the current-sense flags.
    always_comb begin
        cs.pwm  = pwm_trip;
        cs.full = ilim_full_trip;
        cs.red  = ilim_red_trip;
    end

    gl_blank_timer #(.BLANK_CLKS(BLANK_CLKS)) u_blank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (turn_on),
        .cs_enable (cs_enable)
    );

    gl_trip_merge u_merge (
        .cs        (cs),
        .cs_enable (cs_enable),
        .burst_sel (burst_sel),
        .ss_trip   (ss_trip),
        .ss_done   (ss_done),
        .duty_win  (duty_win),
        .clr_req   (clr_req)
    );

    gl_latch_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (cyc_start),
        .clr_req   (clr_req),
        .force_off (uv_low),
        .gate      (gate_en),
        .turn_on   (turn_on)
    );
endmodule

// File: rtl/gate_latch_leb_chk.sv
// Module: assertion checker bound to gate_latch_leb; it keeps its own
// count of edges since turn-on to judge the blanking rule.
module gate_latch_leb_chk #(
    parameter int BLANK_CLKS = 28
) (
    input logic clk,
    input logic rst_n,
    input logic cyc_start,
    input logic duty_win,
    input logic pwm_trip,
    input logic ss_trip,
    input logic ss_done,
    input logic ilim_full_trip,
    input logic ilim_red_trip,
    input logic burst_sel,
    input logic uv_low,
    input logic gate_en
);
    localparam int CW = gl_pkg::cnt_width(BLANK_CLKS) + 1;
    logic [CW-1:0] since_on;
    logic          in_blank;
    logic          cs_sel;

    // Edges elapsed since the gate went high, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !gate_en)
            since_on <= '0;
        else if (int'(since_on) < BLANK_CLKS)
            since_on <= since_on + 1'b1;
    end

    always_comb in_blank = gate_en && (int'(since_on) < BLANK_CLKS);
    always_comb cs_sel = pwm_trip | (burst_sel ? ilim_red_trip : ilim_full_trip);

    AST_UV_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_low |=> !gate_en); // R9
    AST_DUTY_END_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_win |=> !gate_en); // R8
    AST_SS_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_trip && !ss_done) |=> !gate_en); // R4
    AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && duty_win && !uv_low && !(ss_trip && !ss_done)
         && !pwm_trip && !ilim_full_trip && !ilim_red_trip) |=> gate_en); // R2
    AST_RISE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> $past(cyc_start)); // R2
    AST_BLANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blank && duty_win && !uv_low && !(ss_trip && !ss_done)) |=> gate_en); // R7
    AST_CS_TRIP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_en && !in_blank && cs_sel) |=> !gate_en); // R3
endmodule

bind gate_latch_leb gate_latch_leb_chk #(.BLANK_CLKS(BLANK_CLKS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cyc_start      (cyc_start),
    .duty_win       (duty_win),
    .pwm_trip       (pwm_trip),
    .ss_trip        (ss_trip),
    .ss_done        (ss_done),
    .ilim_full_trip (ilim_full_trip),
    .ilim_red_trip  (ilim_red_trip),
    .burst_sel      (burst_sel),
    .uv_low         (uv_low),
    .gate_en        (gate_en)
);

// File: tb/tb_gate_latch_leb.sv
// Bench: behavioural reference compared every clock, plus directed checks.
module tb_gate_latch_leb;
    localparam int BLK = 28;

    logic clk = 1'b0;
    logic rst_n, cyc_start, duty_win, pwm_trip, ss_trip, ss_done;
    logic ilim_full_trip, ilim_red_trip, burst_sel, uv_low;
    logic gate_en;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // Reference model state.
    bit m_gate = 1'b0;
    int m_blank = 0;

    always #4ns clk = ~clk;

    gate_latch_leb #(.BLANK_CLKS(BLK)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .duty_win(duty_win),
        .pwm_trip(pwm_trip), .ss_trip(ss_trip), .ss_done(ss_done),
        .ilim_full_trip(ilim_full_trip), .ilim_red_trip(ilim_red_trip),
        .burst_sel(burst_sel), .uv_low(uv_low), .gate_en(gate_en)
    );

    // Reference model: countdown of blanked edges after each turn-on.
    always @(posedge clk) begin
        bit nxt, off, cs_hit;
        if (!rst_n) begin
            m_gate = 1'b0;
            m_blank = 0;
        end else begin
            cs_hit = (m_blank == 0) &&
                     (pwm_trip || (burst_sel ? ilim_red_trip : ilim_full_trip));
            off = uv_low || !duty_win || (ss_trip && !ss_done) || cs_hit;
            nxt = off ? 1'b0 : (cyc_start ? 1'b1 : m_gate);
            if (!m_gate && nxt) m_blank = BLK;
            else if (m_blank > 0) m_blank = m_blank - 1;
            m_gate = nxt;
        end
    end

    task automatic check(input bit exp, input string req);
        checks++;
        if (gate_en !== exp) begin
            fails++;
            $display("FAIL %s: gate_en=%b expected %b at %0t", req, gate_en, exp, $time);
        end
    endtask

    // Advance one clock; compare with the model away from the edge.
    task automatic tick();
        @(negedge clk);
        check(m_gate, cur_req);
    endtask

    task automatic idle_inputs();
        cyc_start = 0; duty_win = 1; pwm_trip = 0; ss_trip = 0; ss_done = 1;
        ilim_full_trip = 0; ilim_red_trip = 0; burst_sel = 0; uv_low = 0;
    endtask

    // Turn the gate on from off with a single start pulse.
    task automatic turn_on_gate();
        cyc_start = 1; tick(); cyc_start = 0;
    endtask

    task automatic gate_off();
        duty_win = 0; tick(); duty_win = 1; tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        idle_inputs();
        rst_n = 0;
        cyc_start = 1;
        repeat (3) @(negedge clk);
        check(1'b0, "R1");                 // R1: reset holds gate low despite start
        cyc_start = 0;
        rst_n = 1;
        tick(); check(1'b0, "R1");

        // R2: start pulse turns the gate on; R11 holds afterwards
        cur_req = "R2";
        turn_on_gate(); check(1'b1, "R2");
        cur_req = "R11";
        repeat (5) tick();
        check(1'b1, "R11");

        // R8: duty window closes
        cur_req = "R8";
        duty_win = 0; tick(); check(1'b0, "R8");
        duty_win = 1; tick(); check(1'b0, "R11");

        // R7 with R3: pwm trip held from the first edge after turn-on
        cur_req = "R7";
        turn_on_gate();
        pwm_trip = 1;
        for (int i = 0; i < BLK; i++) begin
            tick(); check(1'b1, "R7");
        end
        tick(); check(1'b0, "R3");
        pwm_trip = 0; tick();

        // R7: short trip inside the window is ignored
        turn_on_gate();
        repeat (2) tick();
        pwm_trip = 1; ilim_full_trip = 1; tick(); pwm_trip = 0; ilim_full_trip = 0;
        repeat (3) tick();
        check(1'b1, "R7");
        gate_off();

        // R11: second start inside the window does not restart blanking
        cur_req = "R11";
        turn_on_gate();
        tick();
        cyc_start = 1; tick(); cyc_start = 0;
        for (int i = 2; i < BLK; i++) tick();
        ilim_full_trip = 1; tick(); check(1'b0, "R11");
        ilim_full_trip = 0; tick();

        // R5: full limit honoured, reduced limit ignored when not in burst
        cur_req = "R5";
        burst_sel = 0;
        turn_on_gate();
        repeat (BLK) tick();
        ilim_red_trip = 1; repeat (3) tick(); check(1'b1, "R5");
        ilim_red_trip = 0; ilim_full_trip = 1; tick(); check(1'b0, "R5");
        ilim_full_trip = 0; tick();

        // R6: in burst, reduced limit honoured and full limit ignored
        cur_req = "R6";
        burst_sel = 1;
        turn_on_gate();
        repeat (BLK) tick();
        ilim_full_trip = 1; repeat (3) tick(); check(1'b1, "R6");
        ilim_full_trip = 0; ilim_red_trip = 1; tick(); check(1'b0, "R6");
        ilim_red_trip = 0; burst_sel = 0; tick();

        // R4: soft-start trip, not blanked, gated by ss_done
        cur_req = "R4";
        ss_done = 1;
        turn_on_gate();
        ss_trip = 1; repeat (2) tick(); check(1'b1, "R4");
        ss_done = 0; tick(); check(1'b0, "R4");
        ss_trip = 0; ss_done = 1; tick();

        // R10: start coincides with resets
        cur_req = "R10";
        ss_done = 0; ss_trip = 1; cyc_start = 1; tick(); check(1'b0, "R10");
        ss_trip = 0; ss_done = 1; duty_win = 0; tick(); check(1'b0, "R10");
        duty_win = 1; cyc_start = 0; tick();

        // R9: undervoltage turns off and overrides a start
        cur_req = "R9";
        turn_on_gate(); check(1'b1, "R2");
        uv_low = 1; tick(); check(1'b0, "R9");
        cyc_start = 1; tick(); check(1'b0, "R9");
        cyc_start = 0; uv_low = 0; tick();

        // R1: reset while the gate is on
        cur_req = "R1";
        turn_on_gate();
        rst_n = 0; tick(); check(1'b0, "R1");
        rst_n = 1; repeat (2) tick();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule